// File: doc/BRIEF.md
# Beep Tone Generator with Shared Output Pin

This block drives one output pin that serves two purposes: it is a plain general-purpose output driven from a one-bit latch, or it carries a square-wave beep tone. A 4-bit command word picks the purpose and the tone. Its top bit chooses tone mode (1) or latch mode (0). Its low three bits choose one of seven tone pitches, or silence.

All pitches come from dividing the block clock, which is nominally 4.5 MHz. A counter in the block flips the tone level every half period. Every command that enables tone mode restarts that counter from zero with the level low, so a change of pitch never produces a pulse shorter than half the new period.

A backup-mode input releases the pin by deasserting its output enable. The pin stays released after backup ends, until software writes either the latch or a command.

Top module: `beep_port_mux`

## Requirements
- R1: In the cycle after a synchronous reset, the pin is enabled (`pin_oe`=1), it is in latch mode, and it drives 0.
- R2: In latch mode, a write on `out_we` stores `out_data`, and `pin_o` shows that value from the next cycle onward.
- R3: A command with bit 3 = 1 selects tone mode. From the cycle after the command, the pin is low for H cycles, then high for H cycles, and so on, where H is half the selected full period.
- R4: Tone code (bits 2..0) maps to full periods in clock cycles as follows: 0→6000, 1→3600, 2→3000, 3→2160, 4→1800, 5→1440, 6→720. At 4.5 MHz these give 0.75, 1.25, 1.5, 2.08, 2.5, 3.125 and 6.25 kHz.
- R5: In tone mode with code 7, the pin is enabled and held low.
- R6: In tone mode, latch writes do not disturb the pin. The latch still stores the value, and a later command with bit 3 = 0 makes the pin show it.
- R7: Every tone-mode command restarts the divider. The pin is low in the cycle after the command, whatever its previous phase, and its first rise comes exactly H cycles later.
- R8: While `backup` is 1, `pin_oe` is 0 from the next cycle. After `backup` returns to 0, `pin_oe` stays 0 until a latch write or a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (nominally 4.5 MHz) |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 4 | Command: bit 3 selects the mode, bits 2..0 select the tone code |
| out_we | input | 1 | Output-latch write strobe |
| out_data | input | 1 | Output-latch write value |
| backup | input | 1 | Backup mode: releases the pin |
| pin_o | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable (0 = high impedance) |

## Verification
The properties assume all inputs are synchronous to `clk` and stable around its rising edge. They also assume `backup` is a level held for whole cycles, and that strobes carry meaningful data only while `rst_n` is high. The bench changes every input on the falling clock edge and issues one write at a time. Each task waits until every expected sample it queued has been compared before the next task begins, so waveform phases from one command never overlap the next. Restart is exercised by issuing each tone command while the previous tone is in its high half, so a divider that failed to restart would show a high pin where low is expected.

// File: rtl/beep_pkg.sv
// Package: shared constants and the tone-code to period mapping.
// Assumes a 4.5 MHz block clock; ratios are full tone periods in cycles.
package beep_pkg;

    localparam int unsigned CODE_W      = 3;
    localparam int unsigned NUM_CODES   = 1 << CODE_W;
    localparam int unsigned SILENT_CODE = NUM_CODES - 1;

    // Full period in clock cycles for each tone code; 0 means silent.
    function automatic int unsigned full_ratio(input int unsigned code);
        case (code)
            0:       return 6000;
            1:       return 3600;
            2:       return 3000;
            3:       return 2160;
            4:       return 1800;
            5:       return 1440;
            6:       return 720;
            default: return 0;
        endcase
    endfunction

    // Largest half period over all codes, used to size the counter.
    function automatic int unsigned max_half();
        int unsigned m;
        m = 0;
        for (int unsigned i = 0; i < NUM_CODES; i++) begin
            if (full_ratio(i) / 2 > m) m = full_ratio(i) / 2;
        end
        return m;
    endfunction

endpackage

// File: rtl/beep_cmd_reg.sv
// Module: holds the mode bit and tone code from the last command write.
// Also raises a one-cycle restart strobe whenever a tone-mode command arrives.
// Assumes CMD_W equals the tone-code width plus one mode bit on top.
module beep_cmd_reg
    import beep_pkg::*;
#(
    parameter int unsigned CMD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_data,
    output logic              beep_mode,
    output logic [CODE_W-1:0] tone_code,
    output logic              tone_restart
);

    localparam int unsigned MODE_BIT = CMD_W - 1;

    // Capture mode and tone code on each command write; reset to latch mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beep_mode <= 1'b0;
            tone_code <= '0;
        end else if (cmd_we) begin
            beep_mode <= cmd_data[MODE_BIT];
            tone_code <= cmd_data[CODE_W-1:0];
        end
    end

    // Restart the divider on the same edge that a tone-mode command lands.
    assign tone_restart = cmd_we & cmd_data[MODE_BIT];

endmodule

// File: rtl/beep_divider.sv
// Module: half-period counter that produces the square tone level.
// The half-period limit for each code is built by a generate loop.
// The level is held low while idle, on restart, or for the silent code.
// Assumes HALF_W can hold the largest half period minus one.
module beep_divider
    import beep_pkg::*;
#(
    parameter int unsigned HALF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tone_lvl
);

    logic [HALF_W-1:0]    lim_tab [NUM_CODES];
    logic [NUM_CODES-1:0] quiet_vec;
    logic [HALF_W-1:0]    cnt_q;
    logic                 lvl_q;

    // Build the per-code half-period limits and silent flags.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        localparam int unsigned RATIO = full_ratio(g);
        if (RATIO != 0) begin : g_tone
            assign lim_tab[g]   = HALF_W'(RATIO / 2 - 1);
            assign quiet_vec[g] = 1'b0;
        end else begin : g_quiet
            assign lim_tab[g]   = '0;
            assign quiet_vec[g] = 1'b1;
        end
    end

    // Count cycles within a half period; flip the level at each limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (restart || !run || quiet_vec[code]) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (cnt_q == lim_tab[code]) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tone_lvl = lvl_q;

endmodule

// File: rtl/beep_pin_mux.sv
// Module: output latch, backup release flag and the pin source select.
// The latch keeps taking writes in every mode; only the pin source changes.
// Assumes backup is a level that is synchronous to clk.
module beep_pin_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic out_we,
    input  logic out_data,
    input  logic cmd_we,
    input  logic backup,
    input  logic beep_mode,
    input  logic tone_lvl,
    output logic pin_o,
    output logic pin_oe
);

    logic latch_q;
    logic float_q;

    // Store every output write, whichever mode the pin is in.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= 1'b0;
        else if (out_we) latch_q <= out_data;
    end

    // Release the pin in backup; reclaim it on the first write after backup.
    always_ff @(posedge clk) begin
        if (!rst_n)                  float_q <= 1'b0;
        else if (backup)             float_q <= 1'b1;
        else if (out_we || cmd_we)   float_q <= 1'b0;
    end

    // Select the pin source; drive 0 while the pin is released.
    always_comb begin
        pin_oe = ~float_q;
        if (float_q)        pin_o = 1'b0;
        else if (beep_mode) pin_o = tone_lvl;
        else                pin_o = latch_q;
    end

endmodule

// File: rtl/beep_port_mux.sv
// Module: top of the tone generator with a shared output pin.
// Connects the command register, the tone divider and the pin mux.
// Assumes a 4.5 MHz clock for the nominal tone pitches.
module beep_port_mux
    import beep_pkg::*;
#(
    parameter int unsigned CMD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_data,
    input  logic             out_we,
    input  logic             out_data,
    input  logic             backup,
    output logic             pin_o,
    output logic             pin_oe
);

    localparam int unsigned HALF_W = $clog2(max_half());

    logic              beep_mode;
    logic [CODE_W-1:0] tone_code;
    logic              tone_restart;
    logic              tone_lvl;

    beep_cmd_reg #(.CMD_W(CMD_W)) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_data     (cmd_data),
        .beep_mode    (beep_mode),
        .tone_code    (tone_code),
        .tone_restart (tone_restart)
    );

    beep_divider #(.HALF_W(HALF_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (beep_mode),
        .restart  (tone_restart),
        .code     (tone_code),
        .tone_lvl (tone_lvl)
    );

    beep_pin_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_we    (out_we),
        .out_data  (out_data),
        .cmd_we    (cmd_we),
        .backup    (backup),
        .beep_mode (beep_mode),
        .tone_lvl  (tone_lvl),
        .pin_o     (pin_o),
        .pin_oe    (pin_oe)
    );

endmodule

// File: rtl/beep_port_mux_chk.sv
// Module: property checker bound to beep_port_mux.
// Assumes inputs are synchronous and that reset is synchronous, active low.
module beep_port_mux_chk
    import beep_pkg::*;
#(
    parameter int unsigned CMD_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [CMD_W-1:0]  cmd_data,
    input logic              out_we,
    input logic              out_data,
    input logic              backup,
    input logic              beep_mode,
    input logic [CODE_W-1:0] tone_code,
    input logic              pin_o,
    input logic              pin_oe
);

    logic past_valid = 1'b0;

    // Mark that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) past_valid <= 1'b1;

    AST_RESET_STATE: assert property (@(posedge clk)
        past_valid && $past(!rst_n) |-> pin_oe && !pin_o);  // R1

    AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_we && !cmd_we && !backup && !beep_mode |=> pin_o == $past(out_data));  // R2

    AST_SILENT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        beep_mode && tone_code == CODE_W'(SILENT_CODE) |-> !pin_o);  // R5

    AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_data[CMD_W-1] && !backup |=> pin_oe && !pin_o);  // R7

    AST_BACKUP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        backup |=> !pin_oe);  // R8

    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe && !backup && !cmd_we && !out_we |=> !pin_oe);  // R8

endmodule

bind beep_port_mux beep_port_mux_chk #(.CMD_W(CMD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_data  (cmd_data),
    .out_we    (out_we),
    .out_data  (out_data),
    .backup    (backup),
    .beep_mode (beep_mode),
    .tone_code (tone_code),
    .pin_o     (pin_o),
    .pin_oe    (pin_oe)
);

// File: tb/beep_port_mux_test.sv
`timescale 1ns/1ps
// Bench: scoreboard of timed pin expectations, checked on falling edges.
module beep_port_mux_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [3:0] cmd_data = 4'd0;
    logic       out_we = 1'b0;
    logic       out_data = 1'b0;
    logic       backup = 1'b0;
    logic       pin_o;
    logic       pin_oe;

    typedef struct {
        int    due;
        logic  o;
        logic  oe;
        logic  chk_o;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic latch_model = 1'b0;

    beep_port_mux uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .out_we   (out_we),
        .out_data (out_data),
        .backup   (backup),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe)
    );

    always #4 clk = ~clk;

    // Count rising edges; expectations are due at a given count.
    always @(posedge clk) cyc <= cyc + 1;

    // Half period from the R4 table.
    function automatic int half_of(input int code);
        case (code)
            0: return 3000;
            1: return 1800;
            2: return 1500;
            3: return 1080;
            4: return 900;
            5: return 720;
            default: return 360;
        endcase
    endfunction

    task automatic push(input int due, input logic o, input logic oe,
                        input logic chk_o, input string req);
        exp_t e;
        e.due = due; e.o = o; e.oe = oe; e.chk_o = chk_o; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare every expectation that falls due at this sample.
    always @(negedge clk) begin : mon
        exp_t e;
        while (sb_q.size() != 0 && sb_q[0].due <= cyc) begin
            e = sb_q.pop_front();
            checks++;
            if (e.due < cyc) begin
                errors++;
                $display("FAIL %s: sample %0d missed (now %0d)", e.req, e.due, cyc);
            end else if (pin_oe !== e.oe || (e.chk_o && pin_o !== e.o)) begin
                errors++;
                $display("FAIL %s: cycle %0d actual o=%b oe=%b expected o=%b oe=%b",
                         e.req, cyc, pin_o, pin_oe, e.o, e.oe);
            end
        end
    end

    task automatic latch_write(input logic v, input string req);
        @(negedge clk);
        out_we = 1'b1; out_data = v; latch_model = v;
        push(cyc + 1, v, 1'b1, 1'b1, req);
        @(negedge clk);
        out_we = 1'b0;
        drain();
    endtask

    task automatic latch_cmd(input string req);
        @(negedge clk);
        cmd_we = 1'b1; cmd_data = 4'b0000;
        push(cyc + 1, latch_model, 1'b1, 1'b1, req);
        @(negedge clk);
        cmd_we = 1'b0;
        drain();
    endtask

    // Tone command; optional latch write of 1 in the first low half (R6).
    task automatic tone(input int code, input bit poke, input string req);
        int h;
        int base;
        int pts[7];
        @(negedge clk);
        cmd_we = 1'b1; cmd_data = {1'b1, 3'(code)};
        base = cyc + 1;
        h = half_of(code);
        if (code == 7) begin
            push(base, 1'b0, 1'b1, 1'b1, req);
            push(base + 50, 1'b0, 1'b1, 1'b1, req);
            push(base + 4000, 1'b0, 1'b1, 1'b1, req);
        end else begin
            pts = '{0, h/2 + 1, h - 1, h, 2*h - 1, 2*h, 3*h};
            foreach (pts[i])
                push(base + pts[i], ((pts[i] / h) % 2) == 1, 1'b1, 1'b1,
                     (poke && i == 1) ? "R6" : req);
        end
        @(negedge clk);
        cmd_we = 1'b0;
        if (poke && code != 7) begin
            while (cyc != base + h/2 - 1) @(negedge clk);
            out_we = 1'b1; out_data = 1'b1; latch_model = 1'b1;
            @(negedge clk);
            out_we = 1'b0;
        end
        drain();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(cyc + 1, 1'b0, 1'b1, 1'b1, "R1");
        drain();
        latch_write(1'b1, "R2");
        latch_write(1'b0, "R2");
        latch_write(1'b1, "R2");
        for (int c = 0; c < 7; c++) tone(c, 1'b0, "R3 R4");
        tone(7, 1'b0, "R5");
        latch_write(1'b0, "R2");
        tone(6, 1'b1, "R3");
        latch_cmd("R6");
        tone(6, 1'b0, "R7");
        tone(6, 1'b0, "R7");
        tone(1, 1'b0, "R7");
        // Backup releases the pin; a latch write reclaims it (R8).
        @(negedge clk);
        backup = 1'b1;
        push(cyc + 1, 1'b0, 1'b0, 1'b0, "R8");
        push(cyc + 6, 1'b0, 1'b0, 1'b0, "R8");
        repeat (8) @(negedge clk);
        backup = 1'b0;
        push(cyc + 1, 1'b0, 1'b0, 1'b0, "R8");
        push(cyc + 20, 1'b0, 1'b0, 1'b0, "R8");
        drain();
        latch_write(1'b1, "R8");
        // Backup again; a tone command reclaims it (R8).
        @(negedge clk);
        backup = 1'b1;
        push(cyc + 2, 1'b0, 1'b0, 1'b0, "R8");
        repeat (4) @(negedge clk);
        backup = 1'b0;
        push(cyc + 10, 1'b0, 1'b0, 1'b0, "R8");
        drain();
        tone(2, 1'b0, "R8");
        finish_run();
    end

endmodule